// File: doc/BRIEF.md
# ATM Transmit Cell Processor

This block sits between the per-channel transmit cell queue and the payload mapper of one line channel. Each cycle in which the mapper asks for a byte, it hands out the next byte of a 53-byte ATM cell. If the queue holds a complete cell when a new cell slot begins, that cell is drained byte by byte. If it does not, an idle (null) cell is made up internally, so the byte stream never stalls.

On the way out the block can do four things, each chosen by a static control input. It can generate the header checksum byte. It can mark the halt bit in the flow-control field on a programmable cycle of cells. It can scramble the 48 payload bytes with a self-synchronous scrambler. It can corrupt one checksum on request, so that the far end's error detection can be tested.

Top module: `atm_tx_cell_proc`

## Requirements
- R1: While reset is held, and after it is released, `out_vld`, `out_sop` and `fifo_pop` are 0 and `out_byte` is 8'h00 until the first cycle with `take` high.
- R2: Each cycle with `take` high produces one byte, which appears on `out_byte` with `out_vld` high one clock later. `out_sop` is high on the first byte of each 53-byte cell and low on the other 52. A cycle with `take` low gives `out_vld` low one clock later.
- R3: If `fifo_cell_rdy` is high when a cell slot begins, `fifo_pop` is high together with `take` for exactly 53 cycles. Header bytes 1-4 and the payload bytes are taken from `fifo_byte`, changed only by the options in R5-R8.
- R4: If `fifo_cell_rdy` is low when a cell slot begins, an idle cell is sent and nothing is popped. Its header bytes are 00 00 00 01, its checksum byte is always generated (8'h52 when no error is injected), and every payload byte is 8'h6A before scrambling.
- R5: With `cfg_hec_en` high, byte 5 is the CRC-8 of the four transmitted header bytes, XORed with 8'h55. The CRC uses polynomial x^8+x^2+x+1, a zero start value and MSB-first order. With `cfg_hec_en` low, byte 5 of a queued cell is passed on unchanged.
- R6: With `cfg_scr_en` high, each of the 48 payload bytes is scrambled MSB first: out = in XOR (the scrambled bit sent 43 payload bits earlier). Header and checksum bytes are never scrambled. The scrambler history is zero after reset, carries over from cell to cell, and is frozen while scrambling is off.
- R7: With `cfg_gfc_en` high, bit 4 of header byte 1 of a queued cell is set on the first such cell and then on every N-th one, and cleared on the others, where N = `cfg_halt_period` (0 and 1 both mean every cell). Idle cells are left unchanged and do not advance the count. The count restarts while `cfg_gfc_en` is low.
- R8: A pulse on `err_trig` inverts bit 0 of the generated checksum on the next cell whose checksum is generated, and on that cell only. Pulses that arrive while an injection is already pending merge into one. A pulse that arrives in the same cycle as a checksum byte applies to a later cell.
- R9: The checksum covers header byte 1 as it is sent, that is, after the halt bit has been changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hec_en | input | 1 | Generate the checksum byte |
| cfg_scr_en | input | 1 | Scramble the payload |
| cfg_gfc_en | input | 1 | Cyclic halt-bit marking |
| cfg_halt_period | input | PER_W (8) | Halt-bit period N, in cells |
| err_trig | input | 1 | One-shot checksum error request |
| fifo_cell_rdy | input | 1 | Queue holds at least one complete cell |
| fifo_byte | input | 8 | Head byte of the queue (first-word fall-through) |
| fifo_pop | output | 1 | Consume the head byte of the queue |
| take | input | 1 | Mapper requests the next byte |
| out_byte | output | 8 | Transmitted byte |
| out_vld | output | 1 | `out_byte` holds a new byte |
| out_sop | output | 1 | First byte of a cell |

## Verification
The halt-bit change and the checksum computation happen on the same header: the checksum must be taken over byte 1 after the marking. Cells with a clear bit 4 and cells with a set bit 4 are therefore sent on a period-3 and a period-1 schedule, and their checksum bytes are compared with a polynomial division done in the bench. A second overlap comes from error injection: a request is raised in exactly the cycle in which the checksum byte is emitted. The test passes only if that cell's checksum stays correct and the following cell carries the inverted bit 0 on top of its own halt-bit marking.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;
  localparam int CELL_BYTES = 53;
  localparam int HDR_BYTES  = 4;
  localparam int HEC_POS    = 4;
  localparam int SCR_TAP    = 43;

  localparam logic [7:0]  HEC_COSET = 8'h55;
  localparam logic [7:0]  IDLE_FILL = 8'h6A;
  localparam logic [7:0]  CRC_POLY  = 8'h07;
  localparam logic [31:0] IDLE_HDR  = 32'h0000_0001;

  typedef struct packed {
    logic [7:0]         data;
    logic [SCR_TAP-1:0] hist;
  } scr_out_t;

  // One byte of CRC-8, MSB first.
  function automatic logic [7:0] crc8_byte(logic [7:0] crc, logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

  // Self-synchronous x^43+1 scrambling of one byte, MSB first.
  function automatic scr_out_t scramble_byte(logic [7:0] d, logic [SCR_TAP-1:0] h);
    scr_out_t r;
    logic     s;
    r.data = '0;
    r.hist = h;
    for (int i = 7; i >= 0; i--) begin
      s         = d[i] ^ r.hist[SCR_TAP-1];
      r.data[i] = s;
      r.hist    = {r.hist[SCR_TAP-2:0], s};
    end
    return r;
  endfunction

  // Header byte k (0..3) of the idle cell.
  function automatic logic [7:0] idle_hdr_byte(logic [1:0] k);
    return IDLE_HDR[8*(3-int'(k)) +: 8];
  endfunction
endpackage

// File: rtl/atm_tx_cell_seq.sv
module atm_tx_cell_seq #(
  parameter int CELL_BYTES = 53,
  parameter int IW         = $clog2(CELL_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          fifo_cell_rdy,
  output logic [IW-1:0] idx,
  output logic          at_start,
  output logic          user_cell
);
  localparam logic [IW-1:0] LAST = IW'(CELL_BYTES - 1);

  logic [IW-1:0] idx_q;
  logic          user_q;

  assign idx       = idx_q;
  assign at_start  = (idx_q == '0);
  assign user_cell = at_start ? fifo_cell_rdy : user_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      user_q <= 1'b0;
    end else if (take) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      if (at_start) user_q <= fifo_cell_rdy;
    end
  end
endmodule

// File: rtl/atm_tx_hdr_gen.sv
module atm_tx_hdr_gen
  import atm_tx_pkg::*;
#(
  parameter int IW    = 6,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [IW-1:0]    idx,
  input  logic             user_cell,
  input  logic [7:0]       src_byte,
  input  logic             cfg_hec_en,
  input  logic             cfg_gfc_en,
  input  logic [PER_W-1:0] cfg_halt_period,
  input  logic             err_trig,
  output logic [7:0]       hdr_byte,
  output logic             hec_gen,
  output logic             err_inject,
  output logic             err_pend
);
  localparam logic [IW-1:0] HEC_I = IW'(HEC_POS);
  localparam logic [IW-1:0] HDR_N = IW'(HDR_BYTES);

  logic [7:0]       crc_q, crc_nx, mod_byte, hec_val;
  logic [PER_W-1:0] halt_cnt;
  logic [PER_W:0]   cnt_inc;
  logic             is_b0, in_hdr, is_hec, mark_cell, halt_now, pend_q;

  assign is_b0     = (idx == '0);
  assign in_hdr    = (idx < HDR_N);
  assign is_hec    = (idx == HEC_I);
  assign mark_cell = cfg_gfc_en && user_cell;
  assign halt_now  = mark_cell && (halt_cnt == '0);
  assign cnt_inc   = {1'b0, halt_cnt} + 1'b1;

  assign mod_byte  = (is_b0 && mark_cell) ? {src_byte[7:5], halt_now, src_byte[3:0]}
                                          : src_byte;
  assign crc_nx    = crc8_byte(is_b0 ? 8'h00 : crc_q, mod_byte);

  assign hec_gen    = cfg_hec_en || !user_cell;
  assign err_pend   = pend_q;
  assign err_inject = take && is_hec && hec_gen && pend_q;
  assign hec_val    = crc_q ^ HEC_COSET ^ {7'b0, pend_q};
  assign hdr_byte   = (is_hec && hec_gen) ? hec_val : mod_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q    <= '0;
      halt_cnt <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (take && in_hdr) crc_q <= crc_nx;
      if (!cfg_gfc_en) begin
        halt_cnt <= '0;
      end else if (take && is_b0 && user_cell) begin
        halt_cnt <= (cnt_inc >= {1'b0, cfg_halt_period}) ? '0 : cnt_inc[PER_W-1:0];
      end
      if (err_trig)        pend_q <= 1'b1;
      else if (err_inject) pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/atm_tx_pay_scr.sv
module atm_tx_pay_scr
  import atm_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take,
  input  logic       is_pay,
  input  logic       cfg_scr_en,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  logic [SCR_TAP-1:0] hist_q;
  scr_out_t           res;
  logic               active;

  assign res    = scramble_byte(din, hist_q);
  assign active = is_pay && cfg_scr_en;
  assign dout   = active ? res.data : din;

  always_ff @(posedge clk) begin
    if (!rst_n)             hist_q <= '0;
    else if (take && active) hist_q <= res.hist;
  end
endmodule

// File: rtl/atm_tx_cell_proc.sv
module atm_tx_cell_proc
  import atm_tx_pkg::*;
#(
  parameter int NBYTES = CELL_BYTES,
  parameter int PER_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_hec_en,
  input  logic             cfg_scr_en,
  input  logic             cfg_gfc_en,
  input  logic [PER_W-1:0] cfg_halt_period,
  input  logic             err_trig,
  input  logic             fifo_cell_rdy,
  input  logic [7:0]       fifo_byte,
  output logic             fifo_pop,
  input  logic             take,
  output logic [7:0]       out_byte,
  output logic             out_vld,
  output logic             out_sop
);
  localparam int IW = $clog2(NBYTES);
  localparam logic [IW-1:0] HEC_I = IW'(HEC_POS);
  localparam logic [IW-1:0] HDR_N = IW'(HDR_BYTES);

  logic [IW-1:0] idx;
  logic          at_start, user_cell, hec_gen, err_inject, err_pend;
  logic [7:0]    src_byte, idle_byte, hdr_byte, pre_scr, scr_byte;
  logic          is_pay;

  atm_tx_cell_seq #(.CELL_BYTES(NBYTES), .IW(IW)) i_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .fifo_cell_rdy(fifo_cell_rdy),
    .idx(idx), .at_start(at_start), .user_cell(user_cell)
  );

  assign idle_byte = (idx < HDR_N) ? idle_hdr_byte(idx[1:0]) : IDLE_FILL;
  assign src_byte  = user_cell ? fifo_byte : idle_byte;
  assign fifo_pop  = take && user_cell;

  atm_tx_hdr_gen #(.IW(IW), .PER_W(PER_W)) i_hdr (
    .clk(clk), .rst_n(rst_n), .take(take), .idx(idx), .user_cell(user_cell),
    .src_byte(src_byte), .cfg_hec_en(cfg_hec_en), .cfg_gfc_en(cfg_gfc_en),
    .cfg_halt_period(cfg_halt_period), .err_trig(err_trig),
    .hdr_byte(hdr_byte), .hec_gen(hec_gen), .err_inject(err_inject),
    .err_pend(err_pend)
  );

  assign is_pay  = (idx > HEC_I);
  assign pre_scr = is_pay ? src_byte : hdr_byte;

  atm_tx_pay_scr i_scr (
    .clk(clk), .rst_n(rst_n), .take(take), .is_pay(is_pay),
    .cfg_scr_en(cfg_scr_en), .din(pre_scr), .dout(scr_byte)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_byte <= '0;
      out_vld  <= 1'b0;
      out_sop  <= 1'b0;
    end else begin
      out_vld <= take;
      if (take) begin
        out_byte <= scr_byte;
        out_sop  <= at_start;
      end else begin
        out_sop  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/atm_tx_cell_chk.sv
module atm_tx_cell_chk
  import atm_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       take,
  input logic       err_trig,
  input logic       fifo_cell_rdy,
  input logic       fifo_pop,
  input logic       at_start,
  input logic       hec_gen,
  input logic       err_inject,
  input logic       err_pend,
  input logic       out_vld,
  input logic       out_sop,
  input logic [7:0] out_byte
);
  logic [5:0] seen;
  logic [7:0] crc_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= '0;
      crc_seen <= '0;
    end else if (out_vld) begin
      if (out_sop) begin
        seen     <= 6'd1;
        crc_seen <= crc8_byte(8'h00, out_byte);
      end else begin
        seen <= seen + 1'b1;
        if (seen < 6'd4) crc_seen <= crc8_byte(crc_seen, out_byte);
      end
    end
  end

  assert_pop_with_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> take);
  assert_user_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && at_start && fifo_cell_rdy) |-> fifo_pop);
  assert_idle_no_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && at_start && !fifo_cell_rdy) |-> !fifo_pop);
  assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_vld);
  assert_sop_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && at_start) |=> out_sop);
  assert_inject_once_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_inject && !err_trig) |=> !err_pend);
  assert_hec_over_sent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_sop && seen == 6'd4 && $past(hec_gen) && !$past(err_inject))
      |-> out_byte == (crc_seen ^ HEC_COSET));
endmodule

bind atm_tx_cell_proc atm_tx_cell_chk i_chk (
  .clk(clk), .rst_n(rst_n), .take(take), .err_trig(err_trig),
  .fifo_cell_rdy(fifo_cell_rdy), .fifo_pop(fifo_pop), .at_start(at_start),
  .hec_gen(hec_gen), .err_inject(err_inject), .err_pend(err_pend),
  .out_vld(out_vld), .out_sop(out_sop), .out_byte(out_byte)
);

// File: tb/test_atm_tx_cell_proc.sv
module test_atm_tx_cell_proc;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cfg_hec_en = 0, cfg_scr_en = 0, cfg_gfc_en = 0;
  logic [7:0] cfg_halt_period = 0;
  logic       err_trig = 0, take = 0, load_req = 0;
  logic       fifo_cell_rdy, fifo_pop, out_vld, out_sop;
  logic [7:0] fifo_byte, out_byte;

  logic [7:0] mem [53];
  int rd_ptr = 53;
  int pops = 0;
  int checks = 0, fails = 0;

  assign fifo_cell_rdy = (rd_ptr == 0);
  assign fifo_byte     = mem[(rd_ptr < 53) ? rd_ptr : 0];

  always @(posedge clk) begin
    if (fifo_pop) pops <= pops + 1;
    if (load_req) rd_ptr <= 0;
    else if (fifo_pop && rd_ptr < 53) rd_ptr <= rd_ptr + 1;
  end

  atm_tx_cell_proc i_atm_tx_cell_proc (
    .clk(clk), .rst_n(rst_n), .cfg_hec_en(cfg_hec_en), .cfg_scr_en(cfg_scr_en),
    .cfg_gfc_en(cfg_gfc_en), .cfg_halt_period(cfg_halt_period), .err_trig(err_trig),
    .fifo_cell_rdy(fifo_cell_rdy), .fifo_byte(fifo_byte), .fifo_pop(fifo_pop),
    .take(take), .out_byte(out_byte), .out_vld(out_vld), .out_sop(out_sop)
  );

  // Bench model state
  bit ring [43];
  int rptr = 0;
  int gcnt = 0;
  bit pend = 0;

  typedef struct packed {
    logic       hec; logic scr; logic gfc; logic [7:0] per; logic err; logic user;
    logic [31:0] hdr; logic [7:0] hec_in; logic [7:0] seed;
  } vec_t;

  localparam vec_t VEC [19] = '{
    '{1'b1,1'b0,1'b0,8'd0,1'b0,1'b1,32'h12345678,8'h00,8'h10},
    '{1'b1,1'b0,1'b0,8'd0,1'b0,1'b0,32'h0,8'h00,8'h00},
    '{1'b0,1'b0,1'b0,8'd0,1'b0,1'b1,32'hA0B0C0D0,8'h3C,8'h21},
    '{1'b1,1'b1,1'b0,8'd0,1'b0,1'b1,32'h0F0E0D0C,8'h00,8'h44},
    '{1'b1,1'b1,1'b0,8'd0,1'b0,1'b0,32'h0,8'h00,8'h00},
    '{1'b1,1'b1,1'b0,8'd0,1'b0,1'b1,32'h55AA55AA,8'h00,8'h99},
    '{1'b1,1'b0,1'b0,8'd0,1'b0,1'b1,32'h01020304,8'h00,8'h07},
    '{1'b1,1'b1,1'b0,8'd0,1'b0,1'b1,32'hCAFE0001,8'h00,8'h80},
    '{1'b1,1'b0,1'b1,8'd3,1'b0,1'b1,32'h00112233,8'h00,8'h01},
    '{1'b1,1'b0,1'b1,8'd3,1'b0,1'b1,32'hF0112233,8'h00,8'h02},
    '{1'b1,1'b0,1'b1,8'd3,1'b0,1'b1,32'hF0112233,8'h00,8'h03},
    '{1'b1,1'b0,1'b1,8'd3,1'b0,1'b1,32'h00445566,8'h00,8'h04},
    '{1'b1,1'b0,1'b1,8'd3,1'b0,1'b0,32'h0,8'h00,8'h00},
    '{1'b1,1'b0,1'b0,8'd0,1'b1,1'b1,32'h11223344,8'h00,8'h05},
    '{1'b1,1'b0,1'b0,8'd0,1'b0,1'b1,32'h11223344,8'h00,8'h06},
    '{1'b0,1'b0,1'b0,8'd0,1'b1,1'b1,32'h99887766,8'hE1,8'h08},
    '{1'b1,1'b0,1'b0,8'd0,1'b0,1'b0,32'h0,8'h00,8'h00},
    '{1'b1,1'b1,1'b1,8'd1,1'b0,1'b1,32'h10203040,8'h00,8'h09},
    '{1'b1,1'b1,1'b1,8'd0,1'b0,1'b1,32'hE0203040,8'h00,8'h0A}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Header checksum by long division of the 32 header bits by 0x107.
  function automatic logic [7:0] hec_model(logic [31:0] h);
    logic [39:0] v;
    v = {h, 8'h00};
    for (int i = 39; i >= 8; i--) if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h107;
    return v[7:0] ^ 8'h55;
  endfunction

  task automatic scr_model(input logic [7:0] d, output logic [7:0] o);
    for (int b = 7; b >= 0; b--) begin
      bit s;
      s = d[b] ^ ring[rptr];
      ring[rptr] = s;
      rptr = (rptr + 1) % 43;
      o[b] = s;
    end
  endtask

  task automatic load_cell(input logic [31:0] hdr, input logic [7:0] hec_in,
                           input logic [7:0] seed);
    @(negedge clk);
    for (int i = 0; i < 4; i++) mem[i] = hdr[8*(3-i) +: 8];
    mem[4] = hec_in;
    for (int i = 0; i < 48; i++) mem[5+i] = seed + 8'(i * 3);
    load_req = 1;
    @(negedge clk);
    load_req = 0;
  endtask

  task automatic pulse_err();
    @(negedge clk);
    err_trig = 1;
    @(negedge clk);
    err_trig = 0;
    pend = 1;
  endtask

  task automatic run_cell(input string req, input bit user, input int trig_at);
    logic [7:0] exp [53];
    logic [7:0] got [53];
    bit sop_ok, vld_ok;
    logic [31:0] h;
    int p0, bad;
    h = user ? {mem[0], mem[1], mem[2], mem[3]} : 32'h00000001;
    if (!cfg_gfc_en) gcnt = 0;
    else if (user) begin
      h[28] = (gcnt == 0);
      gcnt = (gcnt + 1 >= int'(cfg_halt_period)) ? 0 : gcnt + 1;
    end
    for (int i = 0; i < 4; i++) exp[i] = h[8*(3-i) +: 8];
    if (cfg_hec_en || !user) begin
      exp[4] = hec_model(h) ^ {7'b0, pend};
      pend = 0;
    end else exp[4] = mem[4];
    for (int i = 5; i < 53; i++) begin
      logic [7:0] d;
      d = user ? mem[i] : 8'h6A;
      if (cfg_scr_en) scr_model(d, exp[i]); else exp[i] = d;
    end
    p0 = pops;
    sop_ok = 1; vld_ok = 1;
    @(negedge clk);
    take = 1;
    if (trig_at == 0) err_trig = 1;
    for (int i = 0; i < 53; i++) begin
      @(negedge clk);
      err_trig = (i + 1 == trig_at);
      got[i] = out_byte;
      if (out_sop != (i == 0)) sop_ok = 0;
      if (!out_vld) vld_ok = 0;
      if (i == 52) take = 0;
    end
    if (trig_at >= 0) pend = 1;
    bad = -1;
    for (int i = 52; i >= 0; i--) if (got[i] !== exp[i]) bad = i;
    if (bad < 0) check(1, req, "cell bytes", 0, 0);
    else check(0, req, $sformatf("byte%0d", bad), got[bad], exp[bad]);
    check(sop_ok && vld_ok, "R2", "sop/vld framing", {sop_ok, vld_ok}, 2'b11);
    check((pops - p0) == (user ? 53 : 0), user ? "R3" : "R4", "pop count",
          pops - p0, user ? 53 : 0);
    @(negedge clk);
    check(!out_vld, "R2", "vld after take low", out_vld, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 53; i++) mem[i] = 0;
    for (int i = 0; i < 43; i++) ring[i] = 0;
    repeat (3) @(negedge clk);
    check(!out_vld && !fifo_pop && !out_sop, "R1", "in reset",
          {out_vld, fifo_pop, out_sop}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!out_vld && !out_sop && out_byte == 8'h00, "R1", "after reset",
          {out_vld, out_sop, out_byte}, 0);

    // Table walk
    for (int k = 0; k < 19; k++) begin
      string t;
      cfg_hec_en = VEC[k].hec; cfg_scr_en = VEC[k].scr;
      cfg_gfc_en = VEC[k].gfc; cfg_halt_period = VEC[k].per;
      if (VEC[k].err) pulse_err();
      if (VEC[k].user) load_cell(VEC[k].hdr, VEC[k].hec_in, VEC[k].seed);
      t = VEC[k].user ? "R3 R5" : "R4 R5";
      if (VEC[k].scr) t = {t, " R6"};
      if (VEC[k].gfc) t = {t, " R7 R9"};
      if (VEC[k].err) t = {t, " R8"};
      run_cell(t, VEC[k].user, -1);
    end

    // Idle cell checksum value with nothing pending
    cfg_hec_en = 0; cfg_scr_en = 0; cfg_gfc_en = 0;
    check(hec_model(32'h1) == 8'h52, "R4", "idle checksum constant", hec_model(32'h1), 8'h52);
    run_cell("R4", 0, -1);

    // Merged requests: two pulses, one corrupted cell
    cfg_hec_en = 1;
    pulse_err();
    pulse_err();
    load_cell(32'h0A0B0C0D, 8'h00, 8'h30);
    run_cell("R8 merge", 1, -1);
    load_cell(32'h0A0B0C0D, 8'h00, 8'h31);
    run_cell("R8 single", 1, -1);

    // Request raised exactly on the checksum byte, with halt marking running
    cfg_gfc_en = 1; cfg_halt_period = 2;
    load_cell(32'h30000000, 8'h00, 8'h40);
    run_cell("R8 R9 overlap", 1, 4);
    load_cell(32'h30000000, 8'h00, 8'h41);
    run_cell("R8 R9 overlap next", 1, -1);
    load_cell(32'h20000000, 8'h00, 8'h42);
    run_cell("R7 R9 overlap after", 1, -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule